// File: doc/BRIEF.md
# Dual-Clock Up/Down Counter with Jam Load

A small counter that moves up or down under two separate count strobes. One strobe steps it up and the other steps it down. A step is taken only while the opposite strobe rests high. The counter can be cleared or parallel-loaded from four jam inputs at any time, whatever the count strobes are doing. A parameter selects a decade modulus (0 to 9) or a full binary modulus (0 to 15).

Two active-low flags support cascading: a carry flag and a borrow flag. The carry flag drops while the up strobe is low and the count is at its top value. The borrow flag drops while the down strobe is low and the count is zero. Each flag can drive the matching strobe of the next stage directly, because its rising edge falls exactly where that stage must step.

All logic runs on one free-running system clock. The count strobes are treated as ordinary data. Each strobe passes through a two-flop synchronizer and an edge detector. Clear and load are sampled by the same clock, so they act within one system-clock cycle, independent of the count strobes.

Top module: `dualclk_updown_ctr`

## Requirements
- R1: With `clr` high at a system-clock edge, `q` reads 0 after that edge, whatever the state of `load_n` or the count strobes.
- R2: With `clr` low and `load_n` low at an edge, `q` takes the value of `jam` after that edge, and any count strobe activity in that cycle is ignored.
- R3: A rising edge on `up_clk` steps `q` up by one, provided `dn_clk` stays high. The step appears after the third system-clock edge that follows the rise.
- R4: A rising edge on `dn_clk` steps `q` down by one, provided `up_clk` stays high. It has the same three-edge latency as R3.
- R5: `carry_n` is low exactly when, one edge earlier, `q` equalled the top value and the synchronized `up_clk` was low. Otherwise it is high.
- R6: `borrow_n` is low exactly when, one edge earlier, `q` was 0 and the synchronized `dn_clk` was low. Otherwise it is high.
- R7: The top value is 9 when `DECADE`=1 and 15 when `DECADE`=0. An up step from the top value gives 0, and a down step from 0 gives the top value.
- R8: A rising edge on one strobe is ignored while the other strobe is low. It is also ignored when both strobes rise in the same sampled cycle.
- R9: In decade mode, an up step from a loaded value of 10 to 15 gives 0. A down step from such a value gives 9.
- R10: While `rst` is high at an edge, `q` reads 0 and both flags read high after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Master clear, active high |
| load_n | input | 1 | Parallel load enable, active low |
| jam | input | WIDTH | Parallel load value |
| up_clk | input | 1 | Count-up strobe, counts on its rising edge |
| dn_clk | input | 1 | Count-down strobe, counts on its rising edge |
| q | output | WIDTH | Registered count |
| carry_n | output | 1 | Active-low terminal-count flag for up counting |
| borrow_n | output | 1 | Active-low zero flag for down counting |

## Verification
Clear and load reach `q` one system-clock edge after they are sampled. A strobe rise reaches `q` on the third edge after it is driven: two synchronizer edges, then the counting edge. The flags follow a strobe fall on the third edge, and follow a change of `q` one edge after `q` itself changes. Inputs are driven on the falling clock edge. A behavioural model steps on every rising edge with the same latencies and is compared with `q`, `carry_n` and `borrow_n` at every falling edge. The directed checks wait at least these edge counts before they sample.

// File: rtl/dualclk_ctr_pkg.sv
package dualclk_ctr_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;
endpackage

// File: rtl/ctr_edge_sync.sv
module ctr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic lvl_d,
  output logic rise
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '1;            // idle-high strobes: no spurious edge out of reset
    else     sr <= {sr[STAGES-1:0], din};
  end

  assign lvl   = sr[STAGES-1];
  assign lvl_d = sr[STAGES];
  assign rise  = lvl & ~lvl_d;
endmodule

// File: rtl/ctr_step.sv
module ctr_step
  import dualclk_ctr_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int MAXV  = 9
) (
  input  logic [WIDTH-1:0] cur,
  input  step_e            step,
  output logic [WIDTH-1:0] nxt
);
  localparam logic [WIDTH-1:0] TOP = WIDTH'(MAXV);

  always_comb begin
    unique case (step)
      STEP_UP:   nxt = (cur >= TOP) ? '0 : cur + 1'b1;
      STEP_DOWN: nxt = (cur == '0 || cur > TOP) ? TOP : cur - 1'b1;
      default:   nxt = cur;
    endcase
  end
endmodule

// File: rtl/ctr_flags.sv
module ctr_flags #(
  parameter int WIDTH = 4,
  parameter int MAXV  = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] q,
  input  logic             up_lvl,
  input  logic             dn_lvl,
  output logic             carry_n,
  output logic             borrow_n
);
  localparam logic [WIDTH-1:0] TOP = WIDTH'(MAXV);

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_n  <= 1'b1;
      borrow_n <= 1'b1;
    end else begin
      carry_n  <= ~((q == TOP) & ~up_lvl);
      borrow_n <= ~((q == '0)  & ~dn_lvl);
    end
  end
endmodule

// File: rtl/dualclk_updown_ctr.sv
module dualclk_updown_ctr
  import dualclk_ctr_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int DECADE      = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load_n,
  input  logic [WIDTH-1:0] jam,
  input  logic             up_clk,
  input  logic             dn_clk,
  output logic [WIDTH-1:0] q,
  output logic             carry_n,
  output logic             borrow_n
);
  localparam int MAXV = (DECADE != 0) ? 9 : (1 << WIDTH) - 1;

  logic up_lvl, up_lvl_d, up_rise;
  logic dn_lvl, dn_lvl_d, dn_rise;
  logic up_evt, dn_evt;
  step_e step;
  logic [WIDTH-1:0] q_nxt;

  ctr_edge_sync #(.STAGES(SYNC_STAGES)) u_up_sync (
    .clk(clk), .rst(rst), .din(up_clk),
    .lvl(up_lvl), .lvl_d(up_lvl_d), .rise(up_rise)
  );

  ctr_edge_sync #(.STAGES(SYNC_STAGES)) u_dn_sync (
    .clk(clk), .rst(rst), .din(dn_clk),
    .lvl(dn_lvl), .lvl_d(dn_lvl_d), .rise(dn_rise)
  );

  // A step needs the opposite strobe high in both the current and previous sample
  assign up_evt = up_rise & dn_lvl & dn_lvl_d;
  assign dn_evt = dn_rise & up_lvl & up_lvl_d;

  always_comb begin
    if (up_evt)      step = STEP_UP;
    else if (dn_evt) step = STEP_DOWN;
    else             step = STEP_HOLD;
  end

  ctr_step #(.WIDTH(WIDTH), .MAXV(MAXV)) u_step (
    .cur(q), .step(step), .nxt(q_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (clr)     q <= '0;
    else if (!load_n) q <= jam;
    else              q <= q_nxt;
  end

  ctr_flags #(.WIDTH(WIDTH), .MAXV(MAXV)) u_flags (
    .clk(clk), .rst(rst), .q(q), .up_lvl(up_lvl), .dn_lvl(dn_lvl),
    .carry_n(carry_n), .borrow_n(borrow_n)
  );
endmodule

// File: rtl/dualclk_updown_ctr_chk.sv
module dualclk_updown_ctr_chk #(
  parameter int WIDTH = 4,
  parameter int MAXV  = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             clr,
  input logic             load_n,
  input logic [WIDTH-1:0] jam,
  input logic [WIDTH-1:0] q,
  input logic             carry_n,
  input logic             borrow_n,
  input logic             up_lvl,
  input logic             dn_lvl,
  input logic             up_evt,
  input logic             dn_evt
);
  localparam logic [WIDTH-1:0] TOP = WIDTH'(MAXV);

  assert_clear_R1: assert property (@(posedge clk) disable iff (rst)
    clr |=> (q == '0));

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    (!clr && !load_n) |=> (q == $past(jam)));

  assert_step_up_R3: assert property (@(posedge clk) disable iff (rst)
    (up_evt && !clr && load_n && q < TOP) |=> (q == WIDTH'($past(q) + 1'b1)));

  assert_step_down_R4: assert property (@(posedge clk) disable iff (rst)
    (dn_evt && !clr && load_n && q != '0 && q <= TOP) |=> (q == WIDTH'($past(q) - 1'b1)));

  assert_carry_low_R5: assert property (@(posedge clk) disable iff (rst)
    (q == TOP && !up_lvl) |=> !carry_n);

  assert_carry_high_R5: assert property (@(posedge clk) disable iff (rst)
    (q != TOP || up_lvl) |=> carry_n);

  assert_borrow_low_R6: assert property (@(posedge clk) disable iff (rst)
    (q == '0 && !dn_lvl) |=> !borrow_n);

  assert_borrow_high_R6: assert property (@(posedge clk) disable iff (rst)
    (q != '0 || dn_lvl) |=> borrow_n);

  assert_wrap_up_R7: assert property (@(posedge clk) disable iff (rst)
    (up_evt && !clr && load_n && q == TOP) |=> (q == '0));

  assert_wrap_down_R7: assert property (@(posedge clk) disable iff (rst)
    (dn_evt && !clr && load_n && q == '0) |=> (q == TOP));

  assert_gated_up_R8: assert property (@(posedge clk) disable iff (rst)
    ($rose(up_lvl) && !dn_lvl && !clr && load_n) |=> $stable(q));

  assert_gated_down_R8: assert property (@(posedge clk) disable iff (rst)
    ($rose(dn_lvl) && !up_lvl && !clr && load_n) |=> $stable(q));

  assert_illegal_up_R9: assert property (@(posedge clk) disable iff (rst)
    (up_evt && !clr && load_n && q > TOP) |=> (q == '0));
endmodule

bind dualclk_updown_ctr dualclk_updown_ctr_chk #(.WIDTH(WIDTH), .MAXV(MAXV)) u_chk (
  .clk(clk), .rst(rst), .clr(clr), .load_n(load_n), .jam(jam), .q(q),
  .carry_n(carry_n), .borrow_n(borrow_n), .up_lvl(up_lvl), .dn_lvl(dn_lvl),
  .up_evt(up_evt), .dn_evt(dn_evt)
);

// File: tb/test_dualclk_updown_ctr.sv
module test_dualclk_updown_ctr;
  logic clk = 1'b0;
  logic rst = 1'b1, clr = 1'b0, load_n = 1'b1, up_clk = 1'b1, dn_clk = 1'b1;
  logic [3:0] jam = 4'd0;
  logic [3:0] q_dec, q_bin;
  logic cy_dec, bw_dec, cy_bin, bw_bin;
  int compared = 0, mismatched = 0;
  bit finished = 0;

  always #4 clk = ~clk;   // 125 MHz

  dualclk_updown_ctr #(.WIDTH(4), .DECADE(1)) i_dualclk_updown_ctr (
    .clk(clk), .rst(rst), .clr(clr), .load_n(load_n), .jam(jam),
    .up_clk(up_clk), .dn_clk(dn_clk), .q(q_dec), .carry_n(cy_dec), .borrow_n(bw_dec)
  );

  dualclk_updown_ctr #(.WIDTH(4), .DECADE(0)) i_dualclk_updown_ctr_bin (
    .clk(clk), .rst(rst), .clr(clr), .load_n(load_n), .jam(jam),
    .up_clk(up_clk), .dn_clk(dn_clk), .q(q_bin), .carry_n(cy_bin), .borrow_n(bw_bin)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: sampled strobe history and per-instance state
  int hist_up[$] = '{1, 1, 1};
  int hist_dn[$] = '{1, 1, 1};
  int mq[2] = '{0, 0};
  int mc[2] = '{1, 1};
  int mb[2] = '{1, 1};
  int top[2] = '{9, 15};
  string qtag[2] = '{"R10", "R10"};

  always @(posedge clk) begin
    bit up_now, dn_now, up_go, dn_go;
    up_now = hist_up[1] != 0;
    dn_now = hist_dn[1] != 0;
    up_go = up_now && hist_up[2] == 0 && dn_now && hist_dn[2] != 0;
    dn_go = dn_now && hist_dn[2] == 0 && up_now && hist_up[2] != 0;
    for (int k = 0; k < 2; k++) begin
      if (rst) begin
        mq[k] = 0; mc[k] = 1; mb[k] = 1; qtag[k] = "R10";
      end else begin
        mc[k] = (mq[k] == top[k] && !up_now) ? 0 : 1;
        mb[k] = (mq[k] == 0 && !dn_now) ? 0 : 1;
        if (clr) begin
          mq[k] = 0; qtag[k] = "R1";
        end else if (!load_n) begin
          mq[k] = int'(jam); qtag[k] = "R2";
        end else if (up_go) begin
          qtag[k] = (mq[k] > top[k]) ? "R9" : (mq[k] == top[k]) ? "R7" : "R3";
          mq[k] = (mq[k] >= top[k]) ? 0 : mq[k] + 1;
        end else if (dn_go) begin
          qtag[k] = (mq[k] > top[k]) ? "R9" : (mq[k] == 0) ? "R7" : "R4";
          mq[k] = (mq[k] == 0 || mq[k] > top[k]) ? top[k] : mq[k] - 1;
        end else begin
          qtag[k] = "R8";
        end
      end
    end
    if (rst) begin
      hist_up = '{1, 1, 1};
      hist_dn = '{1, 1, 1};
    end else begin
      hist_up.push_front(int'(up_clk)); void'(hist_up.pop_back());
      hist_dn.push_front(int'(dn_clk)); void'(hist_dn.pop_back());
    end
  end

  // Every-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      check(qtag[0], 8'(q_dec), 8'(mq[0]));
      check("R5", 8'(cy_dec), 8'(mc[0]));
      check("R6", 8'(bw_dec), 8'(mb[0]));
      check(qtag[1], 8'(q_bin), 8'(mq[1]));
      check("R5", 8'(cy_bin), 8'(mc[1]));
      check("R6", 8'(bw_bin), 8'(mb[1]));
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic up_pulse();
    @(negedge clk) up_clk = 1'b0;
    tick(4);
    up_clk = 1'b1;
    tick(4);
  endtask

  task automatic dn_pulse();
    @(negedge clk) dn_clk = 1'b0;
    tick(4);
    dn_clk = 1'b1;
    tick(4);
  endtask

  task automatic load_val(logic [3:0] v);
    @(negedge clk) begin load_n = 1'b0; jam = v; end
    tick(1);
    load_n = 1'b1;
    tick(1);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [3:0] held;
    tick(3);
    check("R10", 8'(q_dec), 8'd0);           // R10 reset state
    check("R10", 8'(cy_dec), 8'd1);
    rst = 1'b0;
    tick(2);

    // R3 / R7: twelve up steps, decade wraps, binary does not
    repeat (12) up_pulse();
    check("R7", 8'(q_dec), 8'd2);
    check("R7", 8'(q_bin), 8'd12);

    // R4 / R7: fourteen down steps, both wrap below zero
    repeat (14) dn_pulse();
    check("R7", 8'(q_dec), 8'd8);
    check("R7", 8'(q_bin), 8'd14);

    // R3 and R4 single steps from a loaded value
    load_val(4'd4);
    up_pulse();
    check("R3", 8'(q_dec), 8'd5);
    dn_pulse();
    check("R4", 8'(q_dec), 8'd4);

    // R2: load wins over an up strobe in flight
    @(negedge clk) begin load_n = 1'b0; jam = 4'd3; end
    up_pulse();
    check("R2", 8'(q_dec), 8'd3);
    check("R2", 8'(q_bin), 8'd3);
    load_n = 1'b1;
    tick(2);

    // R1: clear wins over load
    @(negedge clk) begin clr = 1'b1; load_n = 1'b0; jam = 4'd5; end
    tick(2);
    check("R1", 8'(q_dec), 8'd0);
    clr = 1'b0; load_n = 1'b1;
    tick(2);

    // R6: borrow drops while down strobe low at zero
    dn_clk = 1'b0;
    tick(3);
    check("R6", 8'(bw_dec), 8'd0);
    dn_clk = 1'b1;
    tick(4);
    check("R7", 8'(q_dec), 8'd9);
    check("R6", 8'(bw_dec), 8'd1);

    // R5: carry drops while up strobe low at the top value
    load_val(4'd9);
    up_clk = 1'b0;
    tick(3);
    check("R5", 8'(cy_dec), 8'd0);
    check("R5", 8'(cy_bin), 8'd1);
    up_clk = 1'b1;
    tick(4);
    check("R5", 8'(cy_dec), 8'd1);
    check("R7", 8'(q_dec), 8'd0);

    // R9: illegal decade values recover
    load_val(4'd12);
    up_pulse();
    check("R9", 8'(q_dec), 8'd0);
    check("R9", 8'(q_bin), 8'd13);
    load_val(4'd13);
    dn_pulse();
    check("R9", 8'(q_dec), 8'd9);
    check("R9", 8'(q_bin), 8'd12);

    // R8: up edge with down strobe low is ignored
    load_val(4'd6);
    held = q_dec;
    dn_clk = 1'b0;
    tick(3);
    up_pulse();
    check("R8", 8'(q_dec), 8'(held));
    dn_clk = 1'b1;
    tick(4);
    check("R4", 8'(q_dec), 8'd5);

    // R8: simultaneous rises are ignored
    @(negedge clk) begin up_clk = 1'b0; dn_clk = 1'b0; end
    tick(4);
    held = q_dec;
    up_clk = 1'b1; dn_clk = 1'b1;
    tick(5);
    check("R8", 8'(q_dec), 8'(held));

    tick(2);
    finish_run();
  end
endmodule